// File: doc/BRIEF.md
# Instruction Word Decoder with Encoding Checks

This block takes one 32-bit instruction word of a small custom core and splits it, without any clock, into its opcode, its format and its operand fields. It also derives one strobe per operation class and an illegal flag that catches malformed encodings. The register file, the ALU, memory access and pipeline control sit outside it.

The decoded bundle is captured in a register stage whenever the input valid strobe is high, and is presented one clock later with its own valid bit. While the valid strobe is low, the stage keeps the last bundle it captured.

The legality rules are strict. The opcode must lie in 0x00..0x26. A non-shift R-format word must carry a zero shift amount. Every register slot that the format provides but the operation does not read or write must hold the reserved empty-register code (parameter `NOREG`, default 31).

Top module: `insn_decoder`

## Requirements
- R1: For R-format opcodes, `out_src_a`=[25:21], `out_src_b`=[20:16], `out_dst`=[15:11] and `out_shamt`=[10:6], with `out_imm` and `out_jaddr` zero. R-format opcodes are 0x00–0x02, 0x14–0x21, 0x23 and 0x24.
- R2: For I-format opcodes, `out_src_a`=[25:21], `out_dst`=[20:16], `out_imm`=[15:0], `out_src_b`=NOREG, and `out_shamt` and `out_jaddr` are zero. I-format opcodes are 0x03–0x0C, 0x22, 0x25 and 0x26.
- R3: For J-format opcodes (0x0D–0x13), `out_jaddr`=[25:0]. All three register outputs read NOREG, and `out_shamt` and `out_imm` are zero.
- R4: `out_fmt` encodes the format as R=0, I=1, J=2 and unknown=3. `out_cls` has at most one bit set, and the bit positions are:
  - bit0: ALU, for 0x01, 0x02, 0x15, 0x16, 0x19–0x21, 0x25 and 0x26
  - bit1: shift, for 0x17 and 0x18
  - bit2: load, for 0x03–0x07
  - bit3: store, for 0x08–0x0A
  - bit4: immediate-load, for 0x0B and 0x0C
  - bit5: jump, for 0x0D–0x13
  - bit6: compare, for 0x14
  - bit7: interrupt, for 0x22
  - bit8: interrupt-return, for 0x23
  - bit9: halt, for 0x24
  - NOP (0x00) raises no bit.
- R5: An opcode above 0x26 is illegal. It gives format 3, all register outputs NOREG, and zero shift amount, immediate and jump field.
- R6: A nonzero shift amount [10:6] makes an R-format word illegal unless the opcode is 0x17 or 0x18. The rule does not apply to I-format or J-format words.
- R7: The register slots are A=[25:21], B=[20:16] and C=[15:11]; R format has A, B and C, and I format has A and B. A slot that the opcode does not use must equal NOREG, or the word is illegal. The slots each opcode uses are:
  - A and C: 0x01, 0x02, 0x15, 0x16 and 0x1D
  - A and B: loads, stores, 0x14, 0x25 and 0x26
  - B only: 0x0B and 0x0C
  - A, B and C: 0x17–0x1C and 0x1E–0x21
  - none: 0x00, 0x22, 0x23 and 0x24
  - Used slots may hold any value.
- R8: Bits [5:0] of an R-format word never affect legality or any output.
- R9: An illegal word drives all `out_cls` bits low. Its fields are still extracted as R1–R5 state.
- R10: A word presented with `in_valid` high appears on the outputs after the next rising clock edge, with `out_valid` high. When `in_valid` is low, `out_valid` goes low on the next edge and the bundle holds.
- R11: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture strobe for `in_word` |
| in_word | input | 32 | Instruction word to decode |
| out_valid | output | 1 | Bundle captured on the previous edge |
| out_opcode | output | 6 | Opcode field |
| out_fmt | output | 2 | Format code (R4) |
| out_src_a | output | 5 | First source register |
| out_src_b | output | 5 | Second source register |
| out_dst | output | 5 | Destination register |
| out_shamt | output | 5 | Shift amount |
| out_imm | output | 16 | Immediate |
| out_jaddr | output | 26 | Jump address field |
| out_cls | output | 10 | Operation-class strobes (R4) |
| out_illegal | output | 1 | Malformed encoding |

## Verification
The bench places each opcode next to a variant of itself that breaks exactly one rule: a single unused slot off NOREG, a stray shift amount, or an out-of-range opcode. A decoder with a wrong slot-usage table would accept NOT with a live second source, or reject a load whose base is register 31. It also covers I-format words whose immediate bits overlap the R shift-amount position, and R words with junk in [5:0]. A decoder that checks the shift amount regardless of format, or that reads the low six bits, would flag these legal words. Hold and back-to-back captures catch a register stage that reloads on every edge or loses a word.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
  localparam int WORD_W = 32;
  localparam int OPC_W  = 6;
  localparam int REG_W  = 5;
  localparam int IMM_W  = 16;
  localparam int JMP_W  = 26;
  localparam int CLS_N  = 10;
  localparam int SLOT_N = 3;

  typedef enum logic [1:0] {FMT_R = 2'd0, FMT_I = 2'd1, FMT_J = 2'd2, FMT_BAD = 2'd3} fmt_e;

  localparam int CLS_ALU = 0, CLS_SHF = 1, CLS_LD = 2, CLS_ST = 3, CLS_IMM = 4;
  localparam int CLS_JMP = 5, CLS_CMP = 6, CLS_INT = 7, CLS_IRT = 8, CLS_HLT = 9;

  localparam logic [OPC_W-1:0] OPC_LAST = 6'h26;
  localparam logic [OPC_W-1:0] OPC_SHL  = 6'h17;
  localparam logic [OPC_W-1:0] OPC_SHR  = 6'h18;

  // Format of an opcode
  function automatic fmt_e opc_format(input logic [OPC_W-1:0] op);
    case (op) inside
      [6'h00:6'h02], [6'h14:6'h21], 6'h23, 6'h24: return FMT_R;
      [6'h03:6'h0C], 6'h22, 6'h25, 6'h26:         return FMT_I;
      [6'h0D:6'h13]:                              return FMT_J;
      default:                                    return FMT_BAD;
    endcase
  endfunction

  // Register slots the format provides: {A, B, C}
  function automatic logic [SLOT_N-1:0] fmt_slots(input fmt_e f);
    case (f)
      FMT_R:   return 3'b111;
      FMT_I:   return 3'b110;
      default: return 3'b000;
    endcase
  endfunction

  // Register slots the operation actually uses: {A, B, C}
  function automatic logic [SLOT_N-1:0] opc_slot_use(input logic [OPC_W-1:0] op);
    case (op) inside
      6'h01, 6'h02, 6'h15, 6'h16, 6'h1D:                  return 3'b101;
      [6'h03:6'h0A], 6'h14, 6'h25, 6'h26:                 return 3'b110;
      6'h0B, 6'h0C:                                       return 3'b010;
      [6'h17:6'h1C], [6'h1E:6'h21]:                       return 3'b111;
      default:                                            return 3'b000;
    endcase
  endfunction

  // Operation class strobe vector
  function automatic logic [CLS_N-1:0] opc_class(input logic [OPC_W-1:0] op);
    logic [CLS_N-1:0] c;
    c = '0;
    case (op) inside
      6'h01, 6'h02, 6'h15, 6'h16, [6'h19:6'h21], 6'h25, 6'h26: c[CLS_ALU] = 1'b1;
      OPC_SHL, OPC_SHR:                                       c[CLS_SHF] = 1'b1;
      [6'h03:6'h07]:                                          c[CLS_LD]  = 1'b1;
      [6'h08:6'h0A]:                                          c[CLS_ST]  = 1'b1;
      6'h0B, 6'h0C:                                           c[CLS_IMM] = 1'b1;
      [6'h0D:6'h13]:                                          c[CLS_JMP] = 1'b1;
      6'h14:                                                  c[CLS_CMP] = 1'b1;
      6'h22:                                                  c[CLS_INT] = 1'b1;
      6'h23:                                                  c[CLS_IRT] = 1'b1;
      6'h24:                                                  c[CLS_HLT] = 1'b1;
      default:                                                c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/insn_dec_class.sv
module insn_dec_class
  import insn_dec_pkg::*;
(
  input  logic [OPC_W-1:0]  opcode,
  output fmt_e              fmt,
  output logic [CLS_N-1:0]  cls,
  output logic [SLOT_N-1:0] slot_have,
  output logic [SLOT_N-1:0] slot_used,
  output logic              is_shift
);
  always_comb begin
    fmt       = opc_format(opcode);
    cls       = opc_class(opcode);
    slot_have = fmt_slots(fmt);
    slot_used = opc_slot_use(opcode);
    is_shift  = (opcode == OPC_SHL) || (opcode == OPC_SHR);
  end
endmodule

// File: rtl/insn_dec_legal.sv
module insn_dec_legal
  import insn_dec_pkg::*;
#(
  parameter logic [REG_W-1:0] NOREG = 5'd31
) (
  input  logic [25:6]       mid_bits,
  input  fmt_e              fmt,
  input  logic [SLOT_N-1:0] slot_have,
  input  logic [SLOT_N-1:0] slot_used,
  input  logic              is_shift,
  output logic              bad_opc,
  output logic              bad_shamt,
  output logic [SLOT_N-1:0] bad_slot,
  output logic              illegal
);
  localparam int TOP = 25;

  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    localparam int HI = TOP - s * REG_W;
    localparam int MB = SLOT_N - 1 - s;
    assign bad_slot[MB] = slot_have[MB] && !slot_used[MB] &&
                          (mid_bits[HI -: REG_W] != NOREG);
  end

  assign bad_opc   = (fmt == FMT_BAD);
  assign bad_shamt = (fmt == FMT_R) && !is_shift && (mid_bits[10:6] != '0);
  assign illegal   = bad_opc || bad_shamt || (|bad_slot);
endmodule

// File: rtl/insn_dec_fields.sv
module insn_dec_fields
  import insn_dec_pkg::*;
#(
  parameter logic [REG_W-1:0] NOREG = 5'd31
) (
  input  logic [25:0]      body,
  input  fmt_e             fmt,
  output logic [REG_W-1:0] src_a,
  output logic [REG_W-1:0] src_b,
  output logic [REG_W-1:0] dst,
  output logic [REG_W-1:0] shamt,
  output logic [IMM_W-1:0] imm,
  output logic [JMP_W-1:0] jaddr
);
  always_comb begin
    src_a = NOREG;
    src_b = NOREG;
    dst   = NOREG;
    shamt = '0;
    imm   = '0;
    jaddr = '0;
    case (fmt)
      FMT_R: begin
        src_a = body[25:21];
        src_b = body[20:16];
        dst   = body[15:11];
        shamt = body[10:6];
      end
      FMT_I: begin
        src_a = body[25:21];
        dst   = body[20:16];
        imm   = body[15:0];
      end
      FMT_J:   jaddr = body;
      default: ;
    endcase
  end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import insn_dec_pkg::*;
#(
  parameter logic [4:0] NOREG = 5'd31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  output logic        out_valid,
  output logic [5:0]  out_opcode,
  output logic [1:0]  out_fmt,
  output logic [4:0]  out_src_a,
  output logic [4:0]  out_src_b,
  output logic [4:0]  out_dst,
  output logic [4:0]  out_shamt,
  output logic [15:0] out_imm,
  output logic [25:0] out_jaddr,
  output logic [9:0]  out_cls,
  output logic        out_illegal
);
  // Combinational decode events, named for observation
  logic [OPC_W-1:0]  dec_opcode;
  fmt_e              dec_fmt;
  logic [CLS_N-1:0]  dec_cls_raw;
  logic [CLS_N-1:0]  dec_cls;
  logic [SLOT_N-1:0] dec_slot_have, dec_slot_used, dec_bad_slot;
  logic              dec_is_shift, dec_bad_opc, dec_bad_shamt, dec_illegal;
  logic [REG_W-1:0]  dec_src_a, dec_src_b, dec_dst, dec_shamt;
  logic [IMM_W-1:0]  dec_imm;
  logic [JMP_W-1:0]  dec_jaddr;

  assign dec_opcode = in_word[WORD_W-1 -: OPC_W];

  insn_dec_class u_class (
    .opcode    (dec_opcode),
    .fmt       (dec_fmt),
    .cls       (dec_cls_raw),
    .slot_have (dec_slot_have),
    .slot_used (dec_slot_used),
    .is_shift  (dec_is_shift)
  );

  insn_dec_legal #(.NOREG(NOREG)) u_legal (
    .mid_bits  (in_word[25:6]),
    .fmt       (dec_fmt),
    .slot_have (dec_slot_have),
    .slot_used (dec_slot_used),
    .is_shift  (dec_is_shift),
    .bad_opc   (dec_bad_opc),
    .bad_shamt (dec_bad_shamt),
    .bad_slot  (dec_bad_slot),
    .illegal   (dec_illegal)
  );

  insn_dec_fields #(.NOREG(NOREG)) u_fields (
    .body  (in_word[JMP_W-1:0]),
    .fmt   (dec_fmt),
    .src_a (dec_src_a),
    .src_b (dec_src_b),
    .dst   (dec_dst),
    .shamt (dec_shamt),
    .imm   (dec_imm),
    .jaddr (dec_jaddr)
  );

  assign dec_cls = dec_illegal ? '0 : dec_cls_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_opcode  <= '0;
      out_fmt     <= '0;
      out_src_a   <= '0;
      out_src_b   <= '0;
      out_dst     <= '0;
      out_shamt   <= '0;
      out_imm     <= '0;
      out_jaddr   <= '0;
      out_cls     <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_opcode  <= dec_opcode;
        out_fmt     <= dec_fmt;
        out_src_a   <= dec_src_a;
        out_src_b   <= dec_src_b;
        out_dst     <= dec_dst;
        out_shamt   <= dec_shamt;
        out_imm     <= dec_imm;
        out_jaddr   <= dec_jaddr;
        out_cls     <= dec_cls;
        out_illegal <= dec_illegal;
      end
    end
  end
endmodule

// File: rtl/insn_decoder_chk.sv
module insn_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       out_valid,
  input logic [5:0] out_opcode,
  input logic [1:0] out_fmt,
  input logic [4:0] out_shamt,
  input logic [9:0] out_cls,
  input logic       out_illegal
);
  p_cls_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_cls));

  p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_opcode > 6'h26) |-> (out_illegal && out_fmt == 2'd3));

  p_shamt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_illegal && out_shamt != 5'd0) |-> out_cls[1]);

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_cls == 10'd0));

  p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_opcode) && $stable(out_cls) && $stable(out_illegal)));
endmodule

bind insn_decoder insn_decoder_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .out_opcode  (out_opcode),
  .out_fmt     (out_fmt),
  .out_shamt   (out_shamt),
  .out_cls     (out_cls),
  .out_illegal (out_illegal)
);

// File: tb/insn_decoder_tb_top.sv
module insn_decoder_tb_top;
  localparam logic [4:0] NR = 5'd31;
  localparam int NV = 36;

  // Entry: {opcode, slotA, slotB, slotC, shamt, low6, expected illegal}
  localparam logic [32:0] VEC [NV] = '{
    {6'h00, NR,    NR,    NR,    5'd0,  6'd0,  1'b0},
    {6'h00, 5'd3,  NR,    NR,    5'd0,  6'd0,  1'b1},
    {6'h01, 5'd2,  NR,    5'd5,  5'd0,  6'd0,  1'b0},
    {6'h01, 5'd2,  5'd4,  5'd5,  5'd0,  6'd0,  1'b1},
    {6'h02, 5'd1,  NR,    5'd1,  5'd0,  6'd0,  1'b0},
    {6'h02, 5'd1,  NR,    5'd1,  5'd3,  6'd0,  1'b1},
    {6'h03, 5'd2,  5'd3,  5'd4,  5'd1,  6'd3,  1'b0},
    {6'h07, NR,    5'd0,  5'd0,  5'd0,  6'd8,  1'b0},
    {6'h0A, 5'd6,  5'd7,  5'd31, 5'd31, 6'd63, 1'b0},
    {6'h0B, NR,    5'd9,  5'd1,  5'd2,  6'd3,  1'b0},
    {6'h0B, 5'd0,  5'd9,  5'd1,  5'd2,  6'd3,  1'b1},
    {6'h0C, NR,    NR,    5'd0,  5'd0,  6'd0,  1'b0},
    {6'h0D, 5'd0,  5'd1,  5'd2,  5'd3,  6'd4,  1'b0},
    {6'h13, NR,    5'd17, 5'd9,  5'd30, 6'd1,  1'b0},
    {6'h14, 5'd1,  5'd2,  NR,    5'd0,  6'd0,  1'b0},
    {6'h14, 5'd1,  5'd2,  5'd3,  5'd0,  6'd0,  1'b1},
    {6'h15, 5'd4,  NR,    5'd4,  5'd0,  6'd0,  1'b0},
    {6'h16, 5'd4,  5'd0,  5'd4,  5'd0,  6'd0,  1'b1},
    {6'h17, 5'd1,  NR,    5'd2,  5'd5,  6'd0,  1'b0},
    {6'h18, 5'd1,  5'd3,  5'd2,  5'd31, 6'd0,  1'b0},
    {6'h19, 5'd1,  5'd2,  5'd3,  5'd0,  6'd63, 1'b0},
    {6'h19, 5'd1,  5'd2,  5'd3,  5'd1,  6'd0,  1'b1},
    {6'h1D, 5'd1,  NR,    5'd2,  5'd0,  6'd0,  1'b0},
    {6'h1D, 5'd1,  5'd5,  5'd2,  5'd0,  6'd0,  1'b1},
    {6'h21, 5'd1,  5'd2,  5'd3,  5'd0,  6'd0,  1'b0},
    {6'h22, NR,    NR,    5'd0,  5'd0,  6'd7,  1'b0},
    {6'h22, 5'd2,  NR,    5'd0,  5'd0,  6'd7,  1'b1},
    {6'h23, NR,    NR,    NR,    5'd0,  6'd0,  1'b0},
    {6'h23, NR,    NR,    NR,    5'd0,  6'd5,  1'b0},
    {6'h24, NR,    NR,    NR,    5'd0,  6'd0,  1'b0},
    {6'h24, NR,    NR,    5'd0,  5'd0,  6'd0,  1'b1},
    {6'h24, NR,    NR,    NR,    5'd2,  6'd0,  1'b1},
    {6'h25, 5'd1,  5'd2,  5'd0,  5'd7,  6'd9,  1'b0},
    {6'h26, 5'd3,  5'd4,  5'd31, 5'd31, 6'd63, 1'b0},
    {6'h27, NR,    NR,    NR,    5'd0,  6'd0,  1'b1},
    {6'h3F, 5'd1,  5'd2,  5'd3,  5'd0,  6'd0,  1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        out_valid, out_illegal;
  logic [5:0]  out_opcode;
  logic [1:0]  out_fmt;
  logic [4:0]  out_src_a, out_src_b, out_dst, out_shamt;
  logic [15:0] out_imm;
  logic [25:0] out_jaddr;
  logic [9:0]  out_cls;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  insn_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_opcode(out_opcode), .out_fmt(out_fmt),
    .out_src_a(out_src_a), .out_src_b(out_src_b), .out_dst(out_dst),
    .out_shamt(out_shamt), .out_imm(out_imm), .out_jaddr(out_jaddr),
    .out_cls(out_cls), .out_illegal(out_illegal)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Format per requirement tables: 0=R 1=I 2=J 3=unknown
  function automatic logic [1:0] exp_fmt(input logic [5:0] op);
    if (op <= 6'h02 || (op >= 6'h14 && op <= 6'h21) || op == 6'h23 || op == 6'h24) return 2'd0;
    if ((op >= 6'h03 && op <= 6'h0C) || op == 6'h22 || op == 6'h25 || op == 6'h26) return 2'd1;
    if (op >= 6'h0D && op <= 6'h13) return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [9:0] exp_cls(input logic [5:0] op);
    int b;
    b = -1;
    if (op == 6'h17 || op == 6'h18) b = 1;
    else if (op >= 6'h03 && op <= 6'h07) b = 2;
    else if (op >= 6'h08 && op <= 6'h0A) b = 3;
    else if (op == 6'h0B || op == 6'h0C) b = 4;
    else if (op >= 6'h0D && op <= 6'h13) b = 5;
    else if (op == 6'h14) b = 6;
    else if (op == 6'h22) b = 7;
    else if (op == 6'h23) b = 8;
    else if (op == 6'h24) b = 9;
    else if (op != 6'h00 && op <= 6'h26) b = 0;
    return (b < 0) ? 10'd0 : (10'd1 << b);
  endfunction

  task automatic present(input logic [31:0] w);
    @(negedge clk);
    in_word  = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_bundle(input logic [31:0] w, input logic ill);
    logic [1:0] f;
    f = exp_fmt(w[31:26]);
    check("R10 out_valid", 64'(out_valid), 64'd1);
    check("R5 R6 R7 R8 illegal flag", 64'(out_illegal), 64'(ill));
    check("R4 R9 class strobes", 64'(out_cls), 64'(ill ? 10'd0 : exp_cls(w[31:26])));
    check("R4 format code", 64'(out_fmt), 64'(f));
    case (f)
      2'd0: check("R1 R8 R-format fields",
                  {out_src_a, out_src_b, out_dst, out_shamt, out_imm, out_jaddr},
                  {w[25:21], w[20:16], w[15:11], w[10:6], 16'd0, 26'd0});
      2'd1: check("R2 I-format fields",
                  {out_src_a, out_src_b, out_dst, out_shamt, out_imm, out_jaddr},
                  {w[25:21], NR, w[20:16], 5'd0, w[15:0], 26'd0});
      2'd2: check("R3 J-format fields",
                  {out_src_a, out_src_b, out_dst, out_shamt, out_imm, out_jaddr},
                  {NR, NR, NR, 5'd0, 16'd0, w[25:0]});
      default: check("R5 unknown-opcode fields",
                  {out_src_a, out_src_b, out_dst, out_shamt, out_imm, out_jaddr},
                  {NR, NR, NR, 5'd0, 16'd0, 26'd0});
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 reset outputs",
          {out_valid, out_opcode, out_fmt, out_src_a, out_src_b, out_dst, out_cls, out_illegal},
          '0);
    check("R11 reset fields", {out_shamt, out_imm, out_jaddr}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      present(VEC[i][32:1]);
      check_bundle(VEC[i][32:1], VEC[i][0]);
    end

    // R10: bundle holds while in_valid is low
    present({6'h19, 5'd1, 5'd2, 5'd3, 5'd0, 6'd0});
    in_word = {6'h3F, 26'h3FFFFFF};
    @(negedge clk);
    @(negedge clk);
    check("R10 valid drops", 64'(out_valid), 64'd0);
    check("R10 bundle held", {out_opcode, out_cls, out_illegal, out_dst}, {6'h19, 10'd1, 1'b0, 5'd3});

    // R10: back-to-back captures
    @(negedge clk);
    in_word  = {6'h0D, 26'h2AAAAAA};
    in_valid = 1'b1;
    @(negedge clk);
    check("R10 first of pair jaddr", 64'(out_jaddr), 64'h2AAAAAA);
    in_word = {6'h27, 26'd0};
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 R5 second of pair", {out_valid, out_illegal, out_fmt}, {1'b1, 1'b1, 2'd3});

    // R11: reset clears mid-stream
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset after traffic", {out_valid, out_opcode, out_illegal, out_cls}, '0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule